// File: doc/BRIEF.md
# Hardware Reset Pulse Sequencer

This block watches the active-low external reset pin of a flash-style memory device and turns it into clean, timed control for the rest of the chip. The pin is brought into the clock domain through a synchronizer. While the synchronized pin is low, the data output drivers are disabled and a busy indication is raised. A low pulse only counts as a real reset once it has lasted a minimum width. Shorter glitches leave the sequencing state untouched.

A qualified reset sends a one-cycle abort request to the command logic if an operation was in progress. It also latches a sticky flag which records that a program or erase was cut short, so the affected location can be treated as corrupted. A fixed time after the pin first went low, the block issues a one-cycle request that forces the control state machine back to read mode. This happens even if the pin has already been released. Read access is refused until that request has been issued and a recovery window has passed since the pin last went high.

All three times are given in nanoseconds and converted to clock cycles from a clock-period parameter. Each conversion rounds up. With the defaults (20 ns clock, 500 ns minimum width, 20 us return delay, 1 us recovery) the counts are 25, 1000 and 50 cycles.

Top module: `hw_reset_seq`

## Requirements
- R1: After the system reset, with the pin high, the outputs are: `dq_oe_en`=1, `rst_busy`=0, `read_allow`=1, `abort_req`=0, `rd_mode_force`=0, `op_aborted`=0.
- R2: `dq_oe_en` is 0 and `rst_busy` is 1 exactly while the synchronized pin is low. The synchronizer adds SYNC_STAGES (default 2) clock edges of latency in each direction.
- R3: A low pulse seen for fewer than MIN_CYC cycles is ignored. It produces no abort, no flag and no return-to-read request, and `read_allow` comes back with the pin.
- R4: A low pulse seen for MIN_CYC cycles or more qualifies. If `op_busy` is high on the qualifying edge, `abort_req` is high for exactly one cycle, SYNC_STAGES+MIN_CYC edges after the pin falls.
- R5: `op_aborted` is set when `abort_req` fires and holds until `abort_clr` is high. A set on the same edge as a clear wins, and a qualified reset with `op_busy` low leaves the flag clear.
- R6: A qualified reset produces exactly one `rd_mode_force` pulse, SYNC_STAGES+RET_CYC edges after the pin falls. The pulse comes even if the pin was released earlier.
- R7: After a qualified reset, `read_allow` returns SYNC_STAGES edges after the later of two points: RET_CYC edges after the fall, and REC_CYC edges after the rise.
- R8: A new low during the recovery window is treated as a continuation of the same reset. It raises no new abort, and the recovery window restarts from the next rise.
- R9: Cycle counts are ceil(ns*1000/CLK_PERIOD_PS), with MIN_CYC at least 2 and RET_CYC above MIN_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Active-low on-chip reset of the sequencer flops |
| rst_pin_n | input | 1 | Asynchronous active-low external reset pin |
| op_busy | input | 1 | Program or erase in progress, from the command logic |
| abort_clr | input | 1 | Clears the aborted-operation flag |
| abort_req | output | 1 | One-cycle request to terminate the running operation |
| rd_mode_force | output | 1 | One-cycle request returning the controller to read mode |
| dq_oe_en | output | 1 | Data output driver enable; 0 tri-states the outputs |
| read_allow | output | 1 | Read access permitted |
| rst_busy | output | 1 | Busy indication while the reset pin is low |
| op_aborted | output | 1 | Sticky flag: an operation was cut short by reset |

## Verification
The assertions assume that `op_busy` and `abort_clr` are synchronous to `clk`. They also assume that `sys_rst_n` stays high once released, so the pin sequencing alone drives every state change. The stimulus changes every input only on the falling clock edge and holds `sys_rst_n` high after the opening reset. Pulse lengths are chosen to sit on both sides of each threshold: one cycle short of the minimum width, exactly the minimum, shorter than the return delay plus recovery, and longer than the return delay.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_HELD  = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_t;

  // ceil(ns / period) with the period in picoseconds, never below lo
  function automatic int ns_to_cyc(input int ns, input int period_ps, input int lo);
    int c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c < lo) c = lo;
    return c;
  endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/rst_abort_flag.sv
module rst_abort_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R5
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag); // R5
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int MIN_CYC = 25,
  parameter int RET_CYC = 1000,
  parameter int REC_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic op_busy,
  output logic abort_req,
  output logic force_read,
  output logic read_allow
);
  localparam int RW = $clog2(RET_CYC + 1);
  localparam int QW = $clog2(REC_CYC + 1);
  localparam logic [RW-1:0] MIN_LAST = RW'(MIN_CYC - 1);
  localparam logic [RW-1:0] RET_LAST = RW'(RET_CYC - 1);
  localparam logic [QW-1:0] REC_LAST = QW'(REC_CYC - 1);
  localparam logic [QW-1:0] QMAX     = QW'(REC_CYC);

  seq_state_t state, state_n;
  logic [RW-1:0] rcnt, rcnt_n;
  logic [QW-1:0] qcnt, qcnt_n;
  logic ret_done, ret_done_n;
  logic qual, ret_hit, rec_end;

  always_comb begin
    qual    = (state == ST_ARM) && !pin_s && (rcnt == MIN_LAST);
    ret_hit = (state == ST_HELD || state == ST_RECOV) && !ret_done && (rcnt == RET_LAST);
    rec_end = (state == ST_RECOV) && pin_s && (ret_done || ret_hit) && (qcnt >= REC_LAST);
  end

  always_comb begin
    state_n = state;
    rcnt_n  = rcnt;
    qcnt_n  = '0;
    unique case (state)
      ST_IDLE: begin
        rcnt_n = '0;
        if (!pin_s) begin
          state_n = ST_ARM;
          rcnt_n  = RW'(1);
        end
      end
      ST_ARM: begin
        if (pin_s) begin
          state_n = ST_IDLE;
          rcnt_n  = '0;
        end else begin
          rcnt_n = rcnt + RW'(1);
          if (qual) state_n = ST_HELD;
        end
      end
      ST_HELD: begin
        if (!ret_done) rcnt_n = rcnt + RW'(1);
        if (pin_s) begin
          state_n = ST_RECOV;
          qcnt_n  = QW'(1);
        end
      end
      ST_RECOV: begin
        if (!ret_done) rcnt_n = rcnt + RW'(1);
        qcnt_n = (qcnt == QMAX) ? qcnt : qcnt + QW'(1);
        if (!pin_s)       state_n = ST_HELD;
        else if (rec_end) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
    ret_done_n = (state_n == ST_IDLE) ? 1'b0 : (ret_done | ret_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rcnt       <= '0;
      qcnt       <= '0;
      ret_done   <= 1'b0;
      abort_req  <= 1'b0;
      force_read <= 1'b0;
    end else begin
      state      <= state_n;
      rcnt       <= rcnt_n;
      qcnt       <= qcnt_n;
      ret_done   <= ret_done_n;
      abort_req  <= qual && op_busy;
      force_read <= ret_hit;
    end
  end

  assign read_allow = pin_s && (state == ST_IDLE || state == ST_ARM);

  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req); // R4
  AST_SHORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM && pin_s) |=> (state == ST_IDLE && !abort_req && !force_read)); // R3
  AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    force_read |=> !force_read); // R6
  AST_READ_WAITS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV && !ret_done && !ret_hit) |=> !read_allow); // R7
  AST_NO_REABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOV) |=> !abort_req); // R8
endmodule

// File: rtl/hw_reset_seq.sv
module hw_reset_seq
  import rst_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 20000,
  parameter int T_MIN_NS      = 500,
  parameter int T_RET_NS      = 20000,
  parameter int T_REC_NS      = 1000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic rst_pin_n,
  input  logic op_busy,
  input  logic abort_clr,
  output logic abort_req,
  output logic rd_mode_force,
  output logic dq_oe_en,
  output logic read_allow,
  output logic rst_busy,
  output logic op_aborted
);
  // R9: every window is rounded up to whole clock cycles
  localparam int MIN_CYC = ns_to_cyc(T_MIN_NS, CLK_PERIOD_PS, 2);
  localparam int RET_RAW = ns_to_cyc(T_RET_NS, CLK_PERIOD_PS, 1);
  localparam int RET_CYC = (RET_RAW > MIN_CYC) ? RET_RAW : MIN_CYC + 1;
  localparam int REC_CYC = ns_to_cyc(T_REC_NS, CLK_PERIOD_PS, 1);

  logic pin_s;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .pin_async(rst_pin_n),
    .pin_sync (pin_s)
  );

  rst_seq_ctrl #(.MIN_CYC(MIN_CYC), .RET_CYC(RET_CYC), .REC_CYC(REC_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .pin_s     (pin_s),
    .op_busy   (op_busy),
    .abort_req (abort_req),
    .force_read(rd_mode_force),
    .read_allow(read_allow)
  );

  rst_abort_flag u_flag (
    .clk  (clk),
    .rst_n(sys_rst_n),
    .set  (abort_req),
    .clr  (abort_clr),
    .flag (op_aborted)
  );

  // R2: output drivers and busy follow the synchronized pin
  assign dq_oe_en = pin_s;
  assign rst_busy = ~pin_s;

  AST_NO_READ_WHILE_DRIVERS_OFF: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !dq_oe_en |-> !read_allow); // R2
  AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (!sys_rst_n)
    abort_req |=> op_aborted); // R5
endmodule

// File: tb/sim_hw_reset_seq.sv
module sim_hw_reset_seq;
  localparam int CLK_NS = 20;
  localparam int MIN = (500 * 1000 + 20000 - 1) / 20000;     // 25
  localparam int RET = (20000 * 1000 + 20000 - 1) / 20000;   // 1000
  localparam int REC = (1000 * 1000 + 20000 - 1) / 20000;    // 50
  localparam int SYN = 2;
  localparam int NV  = 8;
  localparam int VLEN [NV] = '{3, MIN-1, MIN, MIN, 100, 1200, 990, 400};
  localparam int VOP  [NV] = '{1, 1,     1,   0,   1,   1,    0,   1};

  logic clk = 1'b0, sys_rst_n = 1'b0, rst_pin_n = 1'b1, op_busy = 1'b0, abort_clr = 1'b0;
  logic abort_req, rd_mode_force, dq_oe_en, read_allow, rst_busy, op_aborted;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hw_reset_seq u0 (.clk(clk), .sys_rst_n(sys_rst_n), .rst_pin_n(rst_pin_n), .op_busy(op_busy),
    .abort_clr(abort_clr), .abort_req(abort_req), .rd_mode_force(rd_mode_force),
    .dq_oe_en(dq_oe_en), .read_allow(read_allow), .rst_busy(rst_busy), .op_aborted(op_aborted));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives the pin low for len cycles, observes every negedge
  task automatic pulse(input int len, input int tail, output int a_at, output int a_n,
                       output int f_at, output int f_n, output int r_back,
                       output int oe_at2, output int busy_at2);
    int c = 0;
    bit was_low = 1'b0;
    a_at = -1; a_n = 0; f_at = -1; f_n = 0; r_back = -1; oe_at2 = -1; busy_at2 = -1;
    rst_pin_n = 1'b0;
    while (c < tail) begin
      @(negedge clk);
      c++;
      if (abort_req) begin a_n++; if (a_at < 0) a_at = c; end
      if (rd_mode_force) begin f_n++; if (f_at < 0) f_at = c; end
      if (c == SYN) begin oe_at2 = dq_oe_en; busy_at2 = rst_busy; end
      if (!read_allow) was_low = 1'b1;
      else if (was_low && r_back < 0) r_back = c;
      if (c == len) rst_pin_n = 1'b1;
    end
  endtask

  initial begin
    int a_at, a_n, f_at, f_n, r_back, oe2, busy2;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dq_oe_en == 1'b1, "R1 oe", dq_oe_en, 1);
    chk(rst_busy == 1'b0, "R1 busy", rst_busy, 0);
    chk(read_allow == 1'b1, "R1 read_allow", read_allow, 1);
    chk({abort_req, rd_mode_force, op_aborted} == 3'b000, "R1 pulses/flag",
        {abort_req, rd_mode_force, op_aborted}, 0);
    // R2 first-edge latency
    rst_pin_n = 1'b0;
    @(negedge clk);
    chk(dq_oe_en == 1'b1, "R2 oe before sync latency", dq_oe_en, 1);
    rst_pin_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int len = VLEN[v];
      bit q = (len >= MIN);
      int exp_r = q ? (((RET > len + REC) ? RET : len + REC) + SYN) : len + SYN;
      op_busy = VOP[v][0];
      pulse(len, exp_r + 20, a_at, a_n, f_at, f_n, r_back, oe2, busy2);
      op_busy = 1'b0;
      chk(oe2 == 0 && busy2 == 1, "R2 oe/busy during pulse", oe2 * 2 + busy2, 1);
      chk(r_back == exp_r, q ? "R7 read return" : "R3 read return", r_back, exp_r);
      if (q && VOP[v] != 0) begin
        chk(a_n == 1 && a_at == MIN + SYN, "R4 abort pulse cycle", a_at, MIN + SYN);
        chk(op_aborted == 1'b1, "R5 flag set", op_aborted, 1);
      end else begin
        chk(a_n == 0, q ? "R5 no abort when idle" : "R3 no abort on short pulse", a_n, 0);
        chk(op_aborted == 1'b0, q ? "R5 flag clear when idle" : "R3 flag clear", op_aborted, 0);
      end
      if (q) chk(f_n == 1 && f_at == RET + SYN, "R6 return-to-read pulse", f_at, RET + SYN);
      else   chk(f_n == 0, "R3 no return-to-read", f_n, 0);
      // R5 flag held then cleared
      repeat (4) @(negedge clk);
      chk(op_aborted == (q && VOP[v] != 0), "R5 flag held", op_aborted, q && VOP[v] != 0);
      abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0; @(negedge clk);
      chk(op_aborted == 1'b0, "R5 flag cleared", op_aborted, 0);
    end

    // R5 set wins over a simultaneous clear
    op_busy = 1'b1; abort_clr = 1'b1;
    pulse(MIN, RET + REC + 10, a_at, a_n, f_at, f_n, r_back, oe2, busy2);
    chk(op_aborted == 1'b0 && a_n == 1, "R5 clear held high later clears", op_aborted, 0);
    abort_clr = 1'b0; op_busy = 1'b0;
    op_busy = 1'b1;
    rst_pin_n = 1'b0;
    repeat (MIN + SYN - 1) @(negedge clk);
    abort_clr = 1'b1;
    @(negedge clk);
    chk(abort_req == 1'b1, "R4 abort with clear pending", abort_req, 1);
    abort_clr = 1'b0; op_busy = 1'b0;
    @(negedge clk);
    chk(op_aborted == 1'b1, "R5 set beats clear", op_aborted, 1);
    rst_pin_n = 1'b1;
    repeat (RET + REC) @(negedge clk);
    abort_clr = 1'b1; @(negedge clk); abort_clr = 1'b0; @(negedge clk);

    // R8 re-assert inside recovery window
    op_busy = 1'b1;
    pulse(1100, 1100 + 20, a_at, a_n, f_at, f_n, r_back, oe2, busy2);
    chk(read_allow == 1'b0, "R8 still recovering", read_allow, 0);
    pulse(5, 5 + REC + SYN + 10, a_at, a_n, f_at, f_n, r_back, oe2, busy2);
    chk(a_n == 0, "R8 no second abort", a_n, 0);
    chk(r_back == 5 + REC + SYN, "R8 recovery restarts", r_back, 5 + REC + SYN);
    chk(f_n == 0, "R8 no second return pulse", f_n, 0);
    op_busy = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule